// File: doc/BRIEF.md
# Standby and Wake-Up Controller

This block puts the processor of a small infrared remote-control controller to sleep and wakes it again. When the core raises a halt request, the controller enters one of two standby modes, chosen by a mode bit sampled with the request. In the clock-running halt the clock stays on and only execution stops. In oscillator stop the clock enable to the rest of the chip is also withdrawn. If the transmit timer is still counting when oscillator stop is requested, execution stops at once. The clock is removed only after the count has ended, so the carrier pattern in progress is not cut short.

Four wake sources can be enabled one by one: the serial input pin, the key I/O lines, the key input lines and timer completion. The three pin sources share one level select, so a wake can be set to trigger on a high level or on a low level. While the clock runs, the pin sources are seen through a two-flop synchronizer. In oscillator stop they are evaluated directly, which lets them restart the clock. An optional hang-up guard raises a reset in oscillator stop when the key I/O port is left in input mode or any key I/O line reads low. Register and memory contents outside this block are untouched by standby, because the block only gates execution and the clock.

Top module: `standby_ctrl`

## Requirements
- R1: After reset the block is in the run state: `cpu_run`=1, `clk_en`=1, `hang_rst`=0.
- R2: `halt_req`=1 with `stop_sel`=0 while running gives `cpu_run`=0 from the next clock edge, and `clk_en` stays 1.
- R3: `halt_req`=1 with `stop_sel`=1 while the timer is idle (`tmr_busy`=0) gives `cpu_run`=0 and `clk_en`=0 from the next clock edge.
- R4: `halt_req`=1 with `stop_sel`=1 while `tmr_busy`=1 gives `cpu_run`=0 at once, keeps `clk_en`=1 while `tmr_busy` stays 1, and drops `clk_en` at the first edge that samples `tmr_busy`=0.
- R5: `wake_sel` enables the wake sources bit by bit: bit 0 is the serial input, bit 1 the key I/O lines, bit 2 the key input lines, bit 3 timer completion. An active source whose bit is 0 does not wake the core.
- R6: With `wake_lvl`=1, a pin source is active when the serial input is high or when any line of the group is high. With `wake_lvl`=0, it is active when the serial input is low or when any line of the group is low.
- R7: The key I/O source is active only while `kio_is_input`=1.
- R8: A one-cycle `tmr_done` pulse with `wake_sel[3]`=1, in the clock-running halt or during a deferred stop, gives `cpu_run`=1 from the next edge.
- R9: In the clock-running halt, a pin change that enables a wake reaches `cpu_run` at the third clock edge after the change, because of the two synchronizer flops and the state register.
- R10: In oscillator stop, an enabled active pin level raises `clk_en` in the same cycle without a clock edge, and `cpu_run` rises at the next edge. With no active source, `clk_en` stays 0.
- R11: With `hang_en`=1 in oscillator stop, `kio_is_input`=1 or any low `kio_in` line raises `hang_rst` and `clk_en` at once, and the next edge returns the block to run with `hang_rst`=0. Outside oscillator stop `hang_rst` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | One-cycle standby request from the core |
| stop_sel | input | 1 | Standby mode: 0 clock-running halt, 1 oscillator stop |
| wake_sel | input | 4 | Wake source enables (bit 0 serial, 1 key I/O, 2 key input, 3 timer) |
| wake_lvl | input | 1 | Active level of the pin sources: 1 high, 0 low |
| ser_in | input | 1 | Serial input pin |
| kio_in | input | KIO_W | Key I/O pin levels |
| kio_is_input | input | 1 | Key I/O port is in input mode |
| ki_in | input | KI_W | Key input pin levels |
| tmr_busy | input | 1 | Transmit timer is counting |
| tmr_done | input | 1 | One-cycle pulse when the count ends |
| hang_en | input | 1 | Hang-up reset option enable |
| clk_en | output | 1 | Clock enable for the rest of the chip |
| cpu_run | output | 1 | Core may execute |
| hang_rst | output | 1 | Hang-up reset request |

## Verification
The assertions assume that the timer never starts or completes while the oscillator is stopped. They also assume that `tmr_done` arrives only in the cycle where `tmr_busy` falls, and that `halt_req` is a single-cycle pulse. The bench respects this: it drops `tmr_busy` before every request that is meant to reach oscillator stop, and it only pulses `tmr_done` alongside that fall or during a clock-running halt. It also returns every input to its inactive level and resets the block between sweep points, so a leftover level cannot satisfy the next case.

// File: rtl/stby_pkg.sv
package stby_pkg;

    localparam int unsigned NUM_SRC = 4;
    localparam int unsigned SRC_SER = 0;
    localparam int unsigned SRC_KIO = 1;
    localparam int unsigned SRC_KI  = 2;
    localparam int unsigned SRC_TMR = 3;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HALT = 2'd1,
        ST_PEND = 2'd2,
        ST_STOP = 2'd3
    } stby_state_e;

    typedef struct packed {
        stby_state_e state;
    } stby_ctl_t;

endpackage

// File: rtl/stby_sync.sv
module stby_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] pipe_d [STAGES];
    logic [W-1:0] pipe_q [STAGES];

    always_comb begin
        pipe_d[0] = din;
        for (int i = 1; i < int'(STAGES); i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) begin
                pipe_q[i] <= '0;
            end
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/stby_wake_eval.sv
module stby_wake_eval
    import stby_pkg::*;
#(
    parameter int unsigned KIO_W = 8,
    parameter int unsigned KI_W  = 4
) (
    input  logic [NUM_SRC-1:0] sel,
    input  logic               lvl,
    input  logic               ser,
    input  logic [KIO_W-1:0]   kio,
    input  logic               kio_is_input,
    input  logic [KI_W-1:0]    ki,
    input  logic               tmr_done,
    output logic               wake
);
    logic [NUM_SRC-1:0] hit;

    always_comb begin
        hit          = '0;
        hit[SRC_SER] = (ser == lvl);
        hit[SRC_KIO] = kio_is_input & (lvl ? (|kio) : ~(&kio));
        hit[SRC_KI]  = lvl ? (|ki) : ~(&ki);
        hit[SRC_TMR] = tmr_done;
        wake         = |(hit & sel);
    end
endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl
    import stby_pkg::*;
#(
    parameter int unsigned KIO_W       = 8,
    parameter int unsigned KI_W        = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               halt_req,
    input  logic               stop_sel,
    input  logic [3:0]         wake_sel,
    input  logic               wake_lvl,
    input  logic               ser_in,
    input  logic [KIO_W-1:0]   kio_in,
    input  logic               kio_is_input,
    input  logic [KI_W-1:0]    ki_in,
    input  logic               tmr_busy,
    input  logic               tmr_done,
    input  logic               hang_en,
    output logic               clk_en,
    output logic               cpu_run,
    output logic               hang_rst
);
    localparam int unsigned PIN_W = 1 + KIO_W + KI_W;

    logic [PIN_W-1:0] pins_raw;
    logic [PIN_W-1:0] pins_syn;
    logic             wake_syn;
    logic             wake_raw;
    logic             hang_hit;
    stby_ctl_t        ctl_d;
    stby_ctl_t        ctl_q;

    assign pins_raw = {ser_in, kio_in, ki_in};

    stby_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pins_raw),
        .dout (pins_syn)
    );

    // clocked path: pins seen after the synchronizer
    stby_wake_eval #(.KIO_W(KIO_W), .KI_W(KI_W)) u_eval_syn (
        .sel         (wake_sel),
        .lvl         (wake_lvl),
        .ser         (pins_syn[PIN_W-1]),
        .kio         (pins_syn[KI_W +: KIO_W]),
        .kio_is_input(kio_is_input),
        .ki          (pins_syn[KI_W-1:0]),
        .tmr_done    (tmr_done),
        .wake        (wake_syn)
    );

    // stopped-clock path: pins evaluated directly
    stby_wake_eval #(.KIO_W(KIO_W), .KI_W(KI_W)) u_eval_raw (
        .sel         (wake_sel),
        .lvl         (wake_lvl),
        .ser         (ser_in),
        .kio         (kio_in),
        .kio_is_input(kio_is_input),
        .ki          (ki_in),
        .tmr_done    (tmr_done),
        .wake        (wake_raw)
    );

    always_comb begin
        ctl_d    = ctl_q;
        hang_hit = hang_en && (ctl_q.state == ST_STOP) &&
                   (kio_is_input || !(&kio_in));
        unique case (ctl_q.state)
            ST_RUN: begin
                if (halt_req) begin
                    if (!stop_sel)     ctl_d.state = ST_HALT;
                    else if (tmr_busy) ctl_d.state = ST_PEND;
                    else               ctl_d.state = ST_STOP;
                end
            end
            ST_HALT: begin
                if (wake_syn) ctl_d.state = ST_RUN;
            end
            ST_PEND: begin
                if (wake_syn)      ctl_d.state = ST_RUN;
                else if (!tmr_busy) ctl_d.state = ST_STOP;
            end
            ST_STOP: begin
                if (wake_raw) ctl_d.state = ST_RUN;
            end
            default: ctl_d.state = ST_RUN;
        endcase
        if (hang_hit) ctl_d.state = ST_RUN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q.state <= ST_RUN;
        else        ctl_q <= ctl_d;
    end

    assign cpu_run  = (ctl_q.state == ST_RUN);
    assign clk_en   = (ctl_q.state != ST_STOP) || wake_raw || hang_hit;
    assign hang_rst = hang_hit;

    assert_halt_stops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_run && halt_req) |=> !cpu_run);

    assert_gated_means_halted_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |-> !cpu_run);

    assert_clock_kept_while_counting_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_run && tmr_busy) |-> clk_en);

    assert_no_source_no_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_run && wake_sel == 4'd0 && !hang_rst) |=> !cpu_run);

    assert_timer_wakes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_run && wake_sel[3] && tmr_done) |=> cpu_run);

    assert_hang_returns_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hang_rst |=> (cpu_run && !hang_rst));
endmodule

// File: tb/standby_ctrl_tb.sv
module standby_ctrl_tb;
    localparam int unsigned KIO_W = 8;
    localparam int unsigned KI_W  = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             halt_req = 1'b0;
    logic             stop_sel = 1'b0;
    logic [3:0]       wake_sel = '0;
    logic             wake_lvl = 1'b1;
    logic             ser_in = 1'b0;
    logic [KIO_W-1:0] kio_in = '0;
    logic             kio_is_input = 1'b1;
    logic [KI_W-1:0]  ki_in = '0;
    logic             tmr_busy = 1'b0;
    logic             tmr_done = 1'b0;
    logic             hang_en = 1'b0;
    logic             clk_en;
    logic             cpu_run;
    logic             hang_rst;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    standby_ctrl #(.KIO_W(KIO_W), .KI_W(KI_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .stop_sel(stop_sel),
        .wake_sel(wake_sel), .wake_lvl(wake_lvl), .ser_in(ser_in),
        .kio_in(kio_in), .kio_is_input(kio_is_input), .ki_in(ki_in),
        .tmr_busy(tmr_busy), .tmr_done(tmr_done), .hang_en(hang_en),
        .clk_en(clk_en), .cpu_run(cpu_run), .hang_rst(hang_rst)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic set_idle(input logic lvl);
        wake_lvl = lvl;
        ser_in   = ~lvl;
        kio_in   = {KIO_W{~lvl}};
        ki_in    = {KI_W{~lvl}};
        tmr_done = 1'b0;
        tmr_busy = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        halt_req = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_halt(input logic stop);
        @(negedge clk);
        halt_req = 1'b1;
        stop_sel = stop;
        @(negedge clk);
        halt_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
    end

    initial begin
        set_idle(1'b1);
        do_reset();
        chk("R1 cpu_run", cpu_run, 1'b1);
        chk("R1 clk_en", clk_en, 1'b1);
        chk("R1 hang_rst", hang_rst, 1'b0);

        // R5 R6 R8 R9 sweep over level, source and enable pattern in clock-running halt
        for (int lv = 0; lv < 2; lv++) begin
            for (int src = 0; src < 4; src++) begin
                for (int sel = 0; sel < 16; sel++) begin
                    logic [3:0] s;
                    s = 4'(sel);
                    set_idle(lv[0]);
                    wake_sel = s;
                    kio_is_input = 1'b1;
                    hang_en = 1'b0;
                    do_reset();
                    do_halt(1'b0);
                    chk("R2 cpu_run", cpu_run, 1'b0);
                    chk("R2 clk_en", clk_en, 1'b1);
                    case (src)
                        0: ser_in = lv[0];
                        1: kio_in[0] = lv[0];
                        2: ki_in[KI_W-1] = lv[0];
                        default: tmr_done = 1'b1;
                    endcase
                    if (src == 3) begin
                        @(negedge clk);
                        tmr_done = 1'b0;
                        chk("R8 R5 timer wake", cpu_run, s[3]);
                    end else begin
                        repeat (2) @(negedge clk);
                        chk("R9 early", cpu_run, 1'b0);
                        @(negedge clk);
                        chk("R5 R6 R9 pin wake", cpu_run, s[src]);
                    end
                end
            end
        end

        // R10 oscillator stop, direct pin evaluation
        for (int lv = 0; lv < 2; lv++) begin
            for (int src = 0; src < 3; src++) begin
                set_idle(lv[0]);
                wake_sel = 4'(1 << src);
                kio_is_input = 1'b1;
                do_reset();
                do_halt(1'b1);
                chk("R3 clk_en", clk_en, 1'b0);
                chk("R3 cpu_run", cpu_run, 1'b0);
                repeat (3) @(negedge clk);
                chk("R10 stays gated", clk_en, 1'b0);
                case (src)
                    0: ser_in = lv[0];
                    1: kio_in[5] = lv[0];
                    default: ki_in[1] = lv[0];
                endcase
                #1;
                chk("R10 clk_en same cycle", clk_en, 1'b1);
                chk("R10 cpu_run before edge", cpu_run, 1'b0);
                @(negedge clk);
                chk("R10 cpu_run after edge", cpu_run, 1'b1);
            end
        end

        // R4 deferred stop
        set_idle(1'b1);
        wake_sel = 4'd0;
        do_reset();
        tmr_busy = 1'b1;
        do_halt(1'b1);
        chk("R4 cpu_run", cpu_run, 1'b0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R4 clk_en while busy", clk_en, 1'b1);
        end
        tmr_busy = 1'b0;
        tmr_done = 1'b1;
        @(negedge clk);
        tmr_done = 1'b0;
        chk("R4 clk_en after count", clk_en, 1'b0);
        chk("R4 cpu_run after count", cpu_run, 1'b0);

        // R8 timer completion during deferred stop
        set_idle(1'b1);
        wake_sel = 4'b1000;
        do_reset();
        tmr_busy = 1'b1;
        do_halt(1'b1);
        repeat (2) @(negedge clk);
        tmr_busy = 1'b0;
        tmr_done = 1'b1;
        @(negedge clk);
        tmr_done = 1'b0;
        chk("R8 deferred wake", cpu_run, 1'b1);
        chk("R8 deferred clk_en", clk_en, 1'b1);

        // R7 key I/O gated by port mode
        set_idle(1'b1);
        wake_sel = 4'b0010;
        kio_is_input = 1'b0;
        do_reset();
        do_halt(1'b0);
        kio_in[3] = 1'b1;
        repeat (5) @(negedge clk);
        chk("R7 output mode no wake", cpu_run, 1'b0);
        kio_is_input = 1'b1;
        @(negedge clk);
        chk("R7 input mode wake", cpu_run, 1'b1);

        // R11 hang-up guard
        set_idle(1'b1);
        wake_sel = 4'd0;
        hang_en = 1'b1;
        kio_in = '1;
        kio_is_input = 1'b0;
        do_reset();
        do_halt(1'b1);
        chk("R11 quiet hang_rst", hang_rst, 1'b0);
        chk("R11 quiet clk_en", clk_en, 1'b0);
        kio_in[2] = 1'b0;
        #1;
        chk("R11 low line hang_rst", hang_rst, 1'b1);
        chk("R11 low line clk_en", clk_en, 1'b1);
        @(negedge clk);
        chk("R11 back to run", cpu_run, 1'b1);
        chk("R11 hang_rst clears", hang_rst, 1'b0);

        kio_in = '1;
        kio_is_input = 1'b1;
        do_halt(1'b1);
        chk("R11 input mode hang_rst", hang_rst, 1'b1);
        @(negedge clk);
        chk("R11 input mode run", cpu_run, 1'b1);

        kio_in[0] = 1'b0;
        do_halt(1'b0);
        repeat (3) @(negedge clk);
        chk("R11 no hang in running halt", hang_rst, 1'b0);
        chk("R11 running halt holds", cpu_run, 1'b0);

        summary();
    end
endmodule